// File: doc/BRIEF.md
# Priority-Routed Peripheral Interrupt Controller

This block gathers a wide set of peripheral interrupt request lines and steers each one onto one of seven shared core priority levels. Software picks the level for every source by writing a 4-bit routing field. For each level the block raises a request output. It also reports the number of the winning source directly, so the interrupt handler does not have to scan status bits to find the cause. A source takes part only when its input is high and its mask bit is set. When several active sources share a level, the one with the lowest source number wins.

A simple word-addressed register bus gives access to the routing fields, the mask banks, the wakeup-enable banks, the live status banks and a spurious-claim counter. The core tells the block which level it is servicing on a per-level claim input. A claim on a level that has no pending request counts as a spurious event. The level outputs are registered, so they follow a change on the inputs or in the configuration after one clock. The wakeup output is a direct OR of the inputs whose wakeup enable is set, and the mask has no effect on it.

Top module: `sic_prio_router`

## Requirements
- R1: The routing field of source n sits in the word at address n/8, bits [(n mod 8)*4 +: 4]. Addresses 0 to 7 are read/write, and a read returns exactly the value last written.
- R2: A routing field value v from 0 to 6 routes the source to level v. That level drives lvl_req bit v, and its winner is reported in lvl_win bits [v*6 +: 6]. Level v corresponds to core priority 7+v.
- R3: A routing field value from 7 to 15 routes the source nowhere. The source then never raises any lvl_req bit.
- R4: A source is active only when irq_in[n] and its mask bit are both 1. Mask bank b is at address 8+b and holds source n at bank n/32, bit n mod 32.
- R5: lvl_req[v] is the OR of the active sources routed to level v. It is registered and reflects the inputs and configuration of the previous clock edge.
- R6: lvl_win field v holds the lowest-numbered active source routed to level v, with the same one-clock timing. The field is 0 when level v has no request.
- R7: Addresses 12 and 13 read irq_in bits [31:0] and [63:32] live. Writes to these addresses have no effect.
- R8: Wakeup-enable bank b is at address 10+b, with the same bit layout as the mask. wake_out is the OR of irq_in AND wakeup enable. The mask does not affect it, and wakeup does not affect lvl_req.
- R9: Address 14 reads a 16-bit spurious counter, zero-extended. On each clock edge it grows by the number of levels whose lvl_ack bit is 1 while the registered lvl_req bit is 0. A claim on a requesting level does not count. Writes to this address have no effect.
- R10: After reset, every routing field is 15, the mask and wakeup banks are 0, the counter is 0, and lvl_req and lvl_win are 0.
- R11: Address 15 is unmapped. It reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_in | input | 64 | Peripheral request lines, level sensitive |
| lvl_ack | input | 7 | Per-level claim from the core |
| lvl_req | output | 7 | Registered request per level |
| lvl_win | output | 42 | Registered winning source number, 6 bits per level |
| wake_out | output | 1 | Wakeup request |

## Verification
Some properties are checked on every cycle. Each raised level must point at a source that was active on the previous edge, and that source's routing field must name the level. An idle level must report winner 0. A request must have an input behind it, and so must a wakeup. Other behaviours only the bench's scenarios and its per-clock reference model can show. These include that the lowest-numbered source wins over higher ones, that values 7 to 15 route nowhere, the exact field packing in the routing words, that writes to the read-only words are ignored, and the exact spurious-counter arithmetic when several levels are claimed at once.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int FIELD_W         = 4;
    localparam int FIELDS_PER_WORD = 8;
    localparam int WORD_W          = 32;

    typedef enum logic [2:0] {
        RG_ASSIGN,
        RG_MASK,
        RG_WAKE,
        RG_STATUS,
        RG_SPUR,
        RG_NONE
    } region_e;
endpackage

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_LVL = 7,
    parameter int CNT_W   = 16,
    parameter int ADDR_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [WORD_W-1:0]          bus_wdata,
    output logic [WORD_W-1:0]          bus_rdata,
    input  logic [NUM_SRC-1:0]         irq_in,
    input  logic [NUM_LVL-1:0]         lvl_ack,
    input  logic [NUM_LVL-1:0]         lvl_req_q,
    output logic [NUM_SRC*FIELD_W-1:0] asg_flat,
    output logic [NUM_SRC-1:0]         mask_flat,
    output logic [NUM_SRC-1:0]         wake_flat
);
    localparam int unsigned ASG_WORDS = NUM_SRC / FIELDS_PER_WORD;
    localparam int unsigned BANKS     = NUM_SRC / WORD_W;
    localparam int unsigned MSK_BASE  = ASG_WORDS;
    localparam int unsigned WAK_BASE  = MSK_BASE + BANKS;
    localparam int unsigned STA_BASE  = WAK_BASE + BANKS;
    localparam int unsigned SPU_ADDR  = STA_BASE + BANKS;

    logic [WORD_W-1:0] asg_q  [ASG_WORDS];
    logic [WORD_W-1:0] mask_q [BANKS];
    logic [WORD_W-1:0] wake_q [BANKS];
    logic [CNT_W-1:0]  cnt_q;
    region_e           region;
    int unsigned       addr_i;

    assign addr_i = 32'(bus_addr);

    // address region decode
    always_comb begin
        if (addr_i < MSK_BASE)       region = RG_ASSIGN;
        else if (addr_i < WAK_BASE)  region = RG_MASK;
        else if (addr_i < STA_BASE)  region = RG_WAKE;
        else if (addr_i < SPU_ADDR)  region = RG_STATUS;
        else if (addr_i == SPU_ADDR) region = RG_SPUR;
        else                         region = RG_NONE;
    end

    // configuration storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(ASG_WORDS); i++) asg_q[i] <= '1;
            for (int b = 0; b < int'(BANKS); b++) begin
                mask_q[b] <= '0;
                wake_q[b] <= '0;
            end
        end else if (bus_wr) begin
            unique case (region)
                RG_ASSIGN:
                    for (int i = 0; i < int'(ASG_WORDS); i++)
                        if (addr_i == unsigned'(i)) asg_q[i] <= bus_wdata;
                RG_MASK:
                    for (int b = 0; b < int'(BANKS); b++)
                        if (addr_i == MSK_BASE + unsigned'(b)) mask_q[b] <= bus_wdata;
                RG_WAKE:
                    for (int b = 0; b < int'(BANKS); b++)
                        if (addr_i == WAK_BASE + unsigned'(b)) wake_q[b] <= bus_wdata;
                default: ;
            endcase
        end
    end

    // spurious claim counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CNT_W'($countones(lvl_ack & ~lvl_req_q));
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (region)
            RG_ASSIGN:
                for (int i = 0; i < int'(ASG_WORDS); i++)
                    if (addr_i == unsigned'(i)) bus_rdata = asg_q[i];
            RG_MASK:
                for (int b = 0; b < int'(BANKS); b++)
                    if (addr_i == MSK_BASE + unsigned'(b)) bus_rdata = mask_q[b];
            RG_WAKE:
                for (int b = 0; b < int'(BANKS); b++)
                    if (addr_i == WAK_BASE + unsigned'(b)) bus_rdata = wake_q[b];
            RG_STATUS:
                for (int b = 0; b < int'(BANKS); b++)
                    if (addr_i == STA_BASE + unsigned'(b)) bus_rdata = irq_in[b*WORD_W +: WORD_W];
            RG_SPUR:  bus_rdata = WORD_W'(cnt_q);
            default:  bus_rdata = '0;
        endcase
    end

    for (genvar gi = 0; gi < int'(ASG_WORDS); gi++) begin : g_asg
        assign asg_flat[gi*WORD_W +: WORD_W] = asg_q[gi];
    end
    for (genvar gb = 0; gb < int'(BANKS); gb++) begin : g_bank
        assign mask_flat[gb*WORD_W +: WORD_W] = mask_q[gb];
        assign wake_flat[gb*WORD_W +: WORD_W] = wake_q[gb];
    end
endmodule

// File: rtl/sic_level_arb.sv
module sic_level_arb
    import sic_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int SRC_W    = 6,
    parameter int LVL_CODE = 0
) (
    input  logic [NUM_SRC-1:0]         active,
    input  logic [NUM_SRC*FIELD_W-1:0] asg_flat,
    output logic                       hit,
    output logic [SRC_W-1:0]           winner
);
    logic [NUM_SRC-1:0] sel;

    always_comb begin
        for (int n = 0; n < NUM_SRC; n++)
            sel[n] = active[n] && (asg_flat[n*FIELD_W +: FIELD_W] == FIELD_W'(LVL_CODE));
    end

    assign hit = |sel;

    // lowest index wins: scan from the top so the last hit kept is the lowest
    always_comb begin
        winner = '0;
        for (int n = NUM_SRC - 1; n >= 0; n--)
            if (sel[n]) winner = SRC_W'(n);
    end
endmodule

// File: rtl/sic_prio_router.sv
module sic_prio_router
    import sic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_LVL = 7,
    parameter int CNT_W   = 16,
    parameter int ADDR_W  = 4,
    parameter int SRC_W   = $clog2(NUM_SRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic [WORD_W-1:0]        bus_rdata,
    input  logic [NUM_SRC-1:0]       irq_in,
    input  logic [NUM_LVL-1:0]       lvl_ack,
    output logic [NUM_LVL-1:0]       lvl_req,
    output logic [NUM_LVL*SRC_W-1:0] lvl_win,
    output logic                     wake_out
);
    logic [NUM_SRC*FIELD_W-1:0] asg_flat;
    logic [NUM_SRC-1:0]         mask_flat;
    logic [NUM_SRC-1:0]         wake_flat;
    logic [NUM_SRC-1:0]         active;
    logic [NUM_LVL-1:0]         hit_c;
    logic [NUM_LVL*SRC_W-1:0]   win_c;
    logic [NUM_LVL-1:0]         req_q;
    logic [NUM_LVL*SRC_W-1:0]   win_q;

    sic_regs #(
        .NUM_SRC (NUM_SRC),
        .NUM_LVL (NUM_LVL),
        .CNT_W   (CNT_W),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .lvl_ack   (lvl_ack),
        .lvl_req_q (req_q),
        .asg_flat  (asg_flat),
        .mask_flat (mask_flat),
        .wake_flat (wake_flat)
    );

    assign active = irq_in & mask_flat;

    for (genvar gv = 0; gv < NUM_LVL; gv++) begin : g_lvl
        sic_level_arb #(
            .NUM_SRC  (NUM_SRC),
            .SRC_W    (SRC_W),
            .LVL_CODE (gv)
        ) u_arb (
            .active   (active),
            .asg_flat (asg_flat),
            .hit      (hit_c[gv]),
            .winner   (win_c[gv*SRC_W +: SRC_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
            win_q <= '0;
        end else begin
            req_q <= hit_c;
            win_q <= win_c;
        end
    end

    assign lvl_req  = req_q;
    assign lvl_win  = win_q;
    assign wake_out = |(irq_in & wake_flat);
endmodule

// File: rtl/sic_prio_router_chk.sv
module sic_prio_router_chk
    import sic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_LVL = 7,
    parameter int SRC_W   = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_SRC-1:0]         irq_in,
    input logic [NUM_SRC-1:0]         active,
    input logic [NUM_SRC*FIELD_W-1:0] asg_flat,
    input logic [NUM_LVL-1:0]         lvl_req,
    input logic [NUM_LVL*SRC_W-1:0]   lvl_win,
    input logic                       wake_out
);
    logic [NUM_SRC-1:0]         prev_active;
    logic [NUM_SRC*FIELD_W-1:0] prev_asg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_active <= '0;
            prev_asg    <= '0;
        end else begin
            prev_active <= active;
            prev_asg    <= asg_flat;
        end
    end

    always @(posedge clk) begin
        if (!rst_n)
            assert_reset_quiet_R10: assert (lvl_req == '0 && lvl_win == '0)
                else $error("level outputs not cleared in reset");
    end

    assert_req_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_req != '0) |-> ($past(irq_in) != '0));

    assert_req_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_req != '0) |-> (prev_active != '0));

    assert_wake_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_out |-> (irq_in != '0));

    for (genvar gv = 0; gv < NUM_LVL; gv++) begin : g_lvl_chk
        assert_idle_win_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !lvl_req[gv] |-> (lvl_win[gv*SRC_W +: SRC_W] == '0));

        assert_win_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_req[gv] |-> prev_active[lvl_win[gv*SRC_W +: SRC_W]]);

        assert_win_routed_R2: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_req[gv] |->
                (prev_asg[32'(lvl_win[gv*SRC_W +: SRC_W])*FIELD_W +: FIELD_W] == FIELD_W'(gv)));
    end
endmodule

bind sic_prio_router sic_prio_router_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_LVL (NUM_LVL),
    .SRC_W   (SRC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .active   (active),
    .asg_flat (asg_flat),
    .lvl_req  (lvl_req),
    .lvl_win  (lvl_win),
    .wake_out (wake_out)
);

// File: tb/sic_prio_router_bench.sv
module sic_prio_router_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 64;
    localparam int NL = 7;
    localparam int SW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NS-1:0] irq_in = '0;
    logic [NL-1:0] lvl_ack = '0;
    logic [NL-1:0] lvl_req;
    logic [NL*SW-1:0] lvl_win;
    logic          wake_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sic_prio_router u_sic_prio_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .lvl_ack   (lvl_ack),
        .lvl_req   (lvl_req),
        .lvl_win   (lvl_win),
        .wake_out  (wake_out)
    );

    // behavioural reference state
    int          m_asg [NS];
    bit [NS-1:0] m_mask;
    bit [NS-1:0] m_wake;
    bit [15:0]   m_cnt;
    bit [NL-1:0] e_req;
    bit [NL*SW-1:0] e_win;

    task automatic cmp(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int a);
        logic [31:0] r;
        r = '0;
        if (a < 8) begin
            for (int k = 0; k < 8; k++) r[k*4 +: 4] = 4'(m_asg[a*8+k]);
        end else if (a < 10) r = m_mask[(a-8)*32 +: 32];
        else if (a < 12)     r = m_wake[(a-10)*32 +: 32];
        else if (a < 14)     r = irq_in[(a-12)*32 +: 32];
        else if (a == 14)    r = {16'h0, m_cnt};
        return r;
    endfunction

    function automatic string tag_of(input int a);
        if (a < 8)       return "R1 routing word read";
        else if (a < 10) return "R4 mask read";
        else if (a < 12) return "R8 wake enable read";
        else if (a < 14) return "R7 status read";
        else if (a == 14) return "R9 counter read";
        return "R11 unmapped read";
    endfunction

    // reference model, advanced on every clock edge
    always @(posedge clk or negedge rst_n) begin : model
        bit [NL-1:0]    nr;
        bit [NL*SW-1:0] nw;
        int             a;
        if (!rst_n) begin
            for (int n = 0; n < NS; n++) m_asg[n] = 15;
            m_mask = '0;
            m_wake = '0;
            m_cnt  = '0;
            e_req  = '0;
            e_win  = '0;
        end else begin
            m_cnt = m_cnt + 16'($countones(lvl_ack & ~e_req));
            nr = '0;
            nw = '0;
            for (int v = 0; v < NL; v++)
                for (int n = 0; n < NS; n++)
                    if (!nr[v] && irq_in[n] && m_mask[n] && m_asg[n] == v) begin
                        nr[v] = 1'b1;
                        nw[v*SW +: SW] = 6'(n);
                    end
            e_req = nr;
            e_win = nw;
            if (bus_wr) begin
                a = int'(bus_addr);
                if (a < 8) begin
                    for (int k = 0; k < 8; k++) m_asg[a*8+k] = int'(bus_wdata[k*4 +: 4]);
                end else if (a < 10) m_mask[(a-8)*32 +: 32] = bus_wdata;
                else if (a < 12)     m_wake[(a-10)*32 +: 32] = bus_wdata;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("R5 level request", 64'(lvl_req), 64'(e_req));
            cmp("R6 level winner", 64'(lvl_win), 64'(e_win));
            cmp("R8 wake output", 64'(wake_out), 64'(|(irq_in & m_wake)));
            cmp(tag_of(int'(bus_addr)), 64'(bus_rdata), 64'(exp_read(int'(bus_addr))));
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk); #1;
        bus_addr = 4'(a);
        #1 d = bus_rdata;
    endtask

    task automatic put(input logic [NS-1:0] v, input logic [NL-1:0] ack);
        @(negedge clk); #1;
        irq_in = v; lvl_ack = ack;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R5 watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stimulus
        logic [31:0] d;
        logic [31:0] d0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        cmp("R10 reset lvl_req", 64'(lvl_req), 64'h0);
        cmp("R10 reset lvl_win", 64'(lvl_win), 64'h0);
        rd(0, d);  cmp("R10 reset routing word", 64'(d), 64'hFFFF_FFFF);
        rd(9, d);  cmp("R10 reset mask", 64'(d), 64'h0);
        rd(10, d); cmp("R10 reset wake enable", 64'(d), 64'h0);
        rd(14, d); cmp("R10 reset counter", 64'(d), 64'h0);

        // routing: src5->2, src3->0, src17->0, src60->0, src40->9
        wr(0, 32'hFF2F_0FFF);
        wr(2, 32'hFFFF_FF0F);
        wr(7, 32'hFFF0_FFFF);
        wr(5, 32'hFFFF_FFF9);
        wr(8, 32'h0002_0028);
        wr(9, 32'h1000_0100);
        rd(0, d); cmp("R1 field packing word 0", 64'(d), 64'hFF2F_0FFF);
        rd(5, d); cmp("R1 field packing word 5", 64'(d), 64'hFFFF_FFF9);

        // R2 and R5 latency
        put(64'h20, '0);
        #1 cmp("R5 no change before edge", 64'(lvl_req), 64'h0);
        @(negedge clk);
        cmp("R2 source 5 on level 2", 64'(lvl_req), 64'b0000100);
        cmp("R2 winner of level 2", 64'(lvl_win[2*SW +: SW]), 64'd5);

        // R3 unrouted field
        put(64'(1) << 40, '0);
        @(negedge clk);
        cmp("R3 field 9 raises nothing", 64'(lvl_req), 64'h0);

        // R6 lowest index first
        put((64'(1) << 3) | (64'(1) << 17) | (64'(1) << 60), '0);
        @(negedge clk);
        cmp("R6 level 0 request", 64'(lvl_req), 64'b0000001);
        cmp("R6 winner is 3", 64'(lvl_win[0 +: SW]), 64'd3);
        put((64'(1) << 17) | (64'(1) << 60), '0);
        @(negedge clk);
        cmp("R6 winner is 17", 64'(lvl_win[0 +: SW]), 64'd17);
        put(64'(1) << 60, '0);
        @(negedge clk);
        cmp("R6 winner is 60", 64'(lvl_win[0 +: SW]), 64'd60);

        // R4 mask and R7 status
        wr(8, 32'h0);
        put(64'h20 | (64'(1) << 17), '0);
        @(negedge clk);
        cmp("R4 masked sources raise nothing", 64'(lvl_req), 64'h0);
        rd(12, d); cmp("R7 status low bank", 64'(d), 64'h0002_0020);
        wr(12, 32'hFFFF_FFFF);
        rd(12, d); cmp("R7 status write ignored", 64'(d), 64'h0002_0020);
        rd(0, d);  cmp("R7 status write left routing alone", 64'(d), 64'hFF2F_0FFF);

        // R8 wakeup independent of mask
        wr(11, 32'h2);
        put(64'(1) << 33, '0);
        @(negedge clk);
        cmp("R8 wake on source 33", 64'(wake_out), 64'h1);
        cmp("R8 no level request from wake", 64'(lvl_req), 64'h0);

        // R9 spurious claims
        rd(14, d0);
        put(64'(1) << 60, 7'b0010000);
        put(64'(1) << 60, 7'b0000000);
        rd(14, d); cmp("R9 claim on idle level counts", 64'(d), 64'(d0 + 1));
        put(64'(1) << 60, 7'b0000001);
        put(64'(1) << 60, 7'b0000000);
        rd(14, d); cmp("R9 claim on requesting level ignored", 64'(d), 64'(d0 + 1));
        put(64'(1) << 60, 7'b0110001);
        put(64'(1) << 60, 7'b0000000);
        rd(14, d); cmp("R9 two idle claims count two", 64'(d), 64'(d0 + 3));
        wr(14, 32'h0);
        rd(14, d); cmp("R9 counter write ignored", 64'(d), 64'(d0 + 3));

        // R11 unmapped
        wr(15, 32'hDEAD_BEEF);
        rd(15, d); cmp("R11 unmapped reads zero", 64'(d), 64'h0);

        // random traffic against the reference model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            irq_in    = {$urandom, $urandom} & {$urandom, $urandom};
            lvl_ack   = 7'($urandom) & 7'($urandom);
            bus_addr  = 4'($urandom);
            bus_wr    = ($urandom % 3) == 0;
            bus_wdata = $urandom;
            if (bus_addr < 4'd8 && ($urandom % 4) != 0) bus_wdata = bus_wdata & 32'h7777_7777;
        end
        @(negedge clk); #1;
        bus_wr = 1'b0;
        lvl_ack = '0;
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule